// File: doc/BRIEF.md
# Serial Command and Fault-Report Port for a 16-Channel Low-Side Switch

This block is the serial slave port of a sixteen-channel low-side switch controller. A host selects the port by pulling chip select low, clocks a 24-bit command word in, and reads a 24-bit status reply out over the same transfer. The reply is frozen when the transfer opens. It carries a summary flag, an overvoltage flag and one fault flag per channel. The command takes effect only when chip select returns high, and only if exactly 24 bits were clocked in.

Serial clock, chip select and data in are brought into the fast system clock through synchronizer chains and edge detectors, so all storage is ordinary synchronous logic. A command word holds a 3-bit opcode in its top bits and 16 bits of channel data in its low bits. Opcodes below the number of implemented registers write the register with that index. Register 0 drives the channel enables.

Top module: `lsd_serial_port`

## Requirements
- R1: An active-low reset clears every command register, so all channel enables are 0 and the serial output is not driven.
- R2: While chip select is high, so_en is 0 and serial clock or data activity changes no register.
- R3: Data in is sampled on serial clock falling edges, most significant bit first. In the received word, bits 23:21 are the opcode, bits 15:0 are the data, and bits 20:16 are ignored.
- R4: On the falling edge of chip select, the reply is loaded as follows: bit 23 is the OR of all fault inputs and the overvoltage input, bit 22 is the overvoltage input, bits 21:16 are 0, and bits 15:0 are the fault inputs, where 1 means faulted. Later input changes within the frame do not alter the reply.
- R5: Reply bit 23 is on the serial output before the first rising serial clock edge. Each rising edge advances the output to the next lower bit.
- R6: On the rising edge of chip select, a 24-bit frame with opcode k below the register count (7) writes its data into register k and leaves the other registers unchanged. Register 0 is the channel-enable output.
- R7: A frame with a bit count other than 24 changes no register.
- R8: A frame whose opcode is the register count or higher (opcode 7) changes no register.
- R9: While chip select is low, so_en is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial reply data |
| so_en | output | 1 | Drive enable for the serial output pad |
| fault_in | input | 16 | Per-channel fault flags, 1 = faulted |
| ovp_in | input | 1 | Supply overvoltage flag |
| chan_on | output | 16 | Channel enable register (register 0) |
| ctl_regs | output | 112 | All command registers, register k at bits [16k+15:16k] |

## Verification
Commands are sent with asymmetric data patterns and with the ignored middle bits set, which separates a correct opcode and data split from a shifted or byte-swapped one. Writes to two different opcodes show that only the addressed register moves. Frames of 23 and 25 bits, an opcode of 7, and clocking with chip select high each try to disturb the registers and must leave them as they were. Replies are read with a single low and a single high fault, with overvoltage alone, with everything clear, and with faults changed during the frame, which separates the header composition from the snapshot timing.

// File: rtl/lsd_spi_pkg.sv
package lsd_spi_pkg;
   // synchronized level with one-cycle edge pulses
   typedef struct packed {
      logic lvl;
      logic rise;
      logic fall;
   } edge_t;
endpackage

// File: rtl/lsd_edge_sync.sv
module lsd_edge_sync
   import lsd_spi_pkg::*;
#(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b0
)(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  din,
   output edge_t q
);
   initial begin
      if (STAGES < 2) $error("lsd_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain  <= {STAGES{RST_VAL}};
         last_q <= RST_VAL;
      end else begin
         chain  <= {chain[STAGES-2:0], din};
         last_q <= chain[STAGES-1];
      end
   end

   always_comb begin
      q.lvl  = chain[STAGES-1];
      q.rise = chain[STAGES-1] & ~last_q;
      q.fall = ~chain[STAGES-1] & last_q;
   end

   a_edge_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(q.rise && q.fall));
endmodule

// File: rtl/lsd_frame_shifter.sv
module lsd_frame_shifter
   import lsd_spi_pkg::*;
#(
   parameter int unsigned FRAME_W = 24,
   parameter int unsigned CH      = 16
)(
   input  logic               clk,
   input  logic               rst_n,
   input  edge_t              cs_e,
   input  edge_t              sck_e,
   input  logic               si_s,
   input  logic [CH-1:0]      fault,
   input  logic               ovp,
   output logic               so_dat,
   output logic               so_drv,
   output logic               wr_stb,
   output logic [FRAME_W-1:0] rx_word
);
   localparam int unsigned PAD_W   = FRAME_W - 2 - CH;
   localparam int unsigned CNT_W   = $clog2(FRAME_W + 2);
   localparam int unsigned CNT_MAX = FRAME_W + 1;

   initial begin
      if (FRAME_W < CH + 2) $error("lsd_frame_shifter: frame too short for header");
   end

   logic [FRAME_W-1:0] tx_sr;
   logic [FRAME_W-1:0] rx_sr;
   logic [CNT_W-1:0]   bit_cnt;
   logic [FRAME_W-1:0] snap;
   logic               sel;

   assign sel = ~cs_e.lvl;

   generate
      if (PAD_W > 0) begin : g_pad
         assign snap = {(|fault) | ovp, ovp, {PAD_W{1'b0}}, fault};
      end else begin : g_nopad
         assign snap = {(|fault) | ovp, ovp, fault};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sr   <= '0;
         rx_sr   <= '0;
         bit_cnt <= '0;
      end else if (cs_e.fall) begin
         tx_sr   <= snap;
         bit_cnt <= '0;
      end else if (sel) begin
         if (sck_e.rise) tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
         if (sck_e.fall) begin
            rx_sr <= {rx_sr[FRAME_W-2:0], si_s};
            if (bit_cnt != CNT_W'(CNT_MAX)) bit_cnt <= bit_cnt + 1'b1;
         end
      end
   end

   assign so_dat  = sel & tx_sr[FRAME_W-1];
   assign so_drv  = sel;
   assign wr_stb  = cs_e.rise && (bit_cnt == CNT_W'(FRAME_W));
   assign rx_word = rx_sr;

   // R5: a rising serial edge advances the reply by one bit
   a_r5_shift_out: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && sck_e.rise && !cs_e.fall) |=> (so_dat == $past(tx_sr[FRAME_W-2])));
   // R3: a falling serial edge captures data in at the bottom
   a_r3_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && sck_e.fall && !cs_e.fall) |=> (rx_sr[0] == $past(si_s)));
   // R7: counter never runs past its saturation point
   a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_W'(CNT_MAX));
   // R2: no capture while deselected
   a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel && !cs_e.fall) |=> $stable(rx_sr));
endmodule

// File: rtl/lsd_cmd_regs.sv
module lsd_cmd_regs #(
   parameter int unsigned FRAME_W  = 24,
   parameter int unsigned CH       = 16,
   parameter int unsigned OP_W     = 3,
   parameter int unsigned NUM_REGS = 7
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_stb,
   input  logic [FRAME_W-1:0]     word,
   output logic [NUM_REGS*CH-1:0] regs_flat
);
   initial begin
      if (NUM_REGS > (1 << OP_W)) $error("lsd_cmd_regs: opcode too narrow");
      if (FRAME_W < OP_W + CH)    $error("lsd_cmd_regs: frame too short");
   end

   logic [OP_W-1:0] opcode;
   logic [CH-1:0]   data;

   assign opcode = word[FRAME_W-1 -: OP_W];
   assign data   = word[CH-1:0];

   for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
      logic [CH-1:0] r_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   r_q <= '0;
         else if (wr_stb && (opcode == OP_W'(k)))      r_q <= data;
      end
      assign regs_flat[k*CH +: CH] = r_q;
   end

   // R8: an opcode with no register behind it changes nothing
   a_r8_bad_op: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && (opcode >= OP_W'(NUM_REGS))) |=> $stable(regs_flat));
   // R6: without a strobe the bank holds
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> $stable(regs_flat));
endmodule

// File: rtl/lsd_serial_port.sv
module lsd_serial_port
   import lsd_spi_pkg::*;
#(
   parameter int unsigned FRAME_W     = 24,
   parameter int unsigned CH          = 16,
   parameter int unsigned OP_W        = 3,
   parameter int unsigned NUM_REGS    = 7,
   parameter int unsigned SYNC_STAGES = 2
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cs_n,
   input  logic                   sclk,
   input  logic                   si,
   output logic                   so,
   output logic                   so_en,
   input  logic [CH-1:0]          fault_in,
   input  logic                   ovp_in,
   output logic [CH-1:0]          chan_on,
   output logic [NUM_REGS*CH-1:0] ctl_regs
);
   edge_t              cs_e, sck_e, si_e;
   logic               wr_stb;
   logic [FRAME_W-1:0] rx_word;

   lsd_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_cs_sync (
      .clk(clk), .rst_n(rst_n), .din(cs_n), .q(cs_e));
   lsd_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sck_sync (
      .clk(clk), .rst_n(rst_n), .din(sclk), .q(sck_e));
   lsd_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_si_sync (
      .clk(clk), .rst_n(rst_n), .din(si), .q(si_e));

   lsd_frame_shifter #(.FRAME_W(FRAME_W), .CH(CH)) i_shift (
      .clk(clk), .rst_n(rst_n), .cs_e(cs_e), .sck_e(sck_e), .si_s(si_e.lvl),
      .fault(fault_in), .ovp(ovp_in), .so_dat(so), .so_drv(so_en),
      .wr_stb(wr_stb), .rx_word(rx_word));

   lsd_cmd_regs #(.FRAME_W(FRAME_W), .CH(CH), .OP_W(OP_W), .NUM_REGS(NUM_REGS)) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .word(rx_word), .regs_flat(ctl_regs));

   assign chan_on = ctl_regs[CH-1:0];

   // R7: a release without a committed frame leaves the registers alone
   a_r7_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_e.rise && !wr_stb) |=> $stable(ctl_regs));
   // R9: the output is driven for the whole selected period
   a_r9_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_e.lvl) |-> so_en);
endmodule

// File: tb/test_lsd_serial_port.sv
module test_lsd_serial_port;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cs_n = 1'b1;
   logic         sclk = 1'b0;
   logic         si = 1'b0;
   logic         so, so_en;
   logic [15:0]  fault_in = '0;
   logic         ovp_in = 1'b0;
   logic [15:0]  chan_on;
   logic [111:0] ctl_regs;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   lsd_serial_port i_lsd_serial_port (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .si(si),
      .so(so), .so_en(so_en), .fault_in(fault_in), .ovp_in(ovp_in),
      .chan_on(chan_on), .ctl_regs(ctl_regs));

   task automatic chk(input string req, input logic [111:0] act, input logic [111:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // one transfer; optionally changes the fault inputs after the reply is frozen
   task automatic spi_frame(input logic [23:0] cmd, input int nbits,
                            input bit chg, input logic [15:0] chg_val,
                            output logic [23:0] rsp, output logic drv);
      rsp = '0;
      @(negedge clk); cs_n = 1'b0;
      wait_clk(6);
      drv = so_en;
      rsp[23] = so;
      if (chg) fault_in = chg_val;
      for (int i = 0; i < nbits; i++) begin
         si = (i < 24) ? cmd[23-i] : 1'b1;
         sclk = 1'b1; wait_clk(4);
         sclk = 1'b0; wait_clk(4);
         if (i < 23) rsp[22-i] = so;
      end
      cs_n = 1'b1;
      wait_clk(6);
   endtask

   function automatic logic [111:0] set_reg(input logic [111:0] b, input int k, input logic [15:0] v);
      logic [111:0] r = b;
      r[k*16 +: 16] = v;
      return r;
   endfunction

   logic [111:0] model = '0;

   task automatic t_reset;
      chk("R1 chan_on after reset", 112'(chan_on), 112'h0);
      chk("R1 registers after reset", ctl_regs, 112'h0);
      chk("R2 so_en idle", 112'(so_en), 112'h0);
   endtask

   task automatic t_write_enables;
      logic [23:0] r; logic d;
      spi_frame({3'd0, 5'h1F, 16'hA5C3}, 24, 1'b0, 16'h0, r, d);
      model = set_reg(model, 0, 16'hA5C3);
      chk("R3 R6 chan_on written", 112'(chan_on), 112'hA5C3);
      chk("R6 bank after opcode 0", ctl_regs, model);
   endtask

   task automatic t_write_other;
      logic [23:0] r; logic d;
      spi_frame({3'd3, 5'h00, 16'h1234}, 24, 1'b0, 16'h0, r, d);
      model = set_reg(model, 3, 16'h1234);
      chk("R6 register 3 written", ctl_regs, model);
      chk("R6 chan_on untouched", 112'(chan_on), 112'hA5C3);
      spi_frame({3'd6, 5'h0A, 16'h8001}, 24, 1'b0, 16'h0, r, d);
      model = set_reg(model, 6, 16'h8001);
      chk("R6 register 6 written", ctl_regs, model);
   endtask

   task automatic t_bad_length;
      logic [23:0] r; logic d;
      spi_frame({3'd0, 5'h0, 16'hFFFF}, 23, 1'b0, 16'h0, r, d);
      chk("R7 23-bit frame dropped", ctl_regs, model);
      spi_frame({3'd0, 5'h0, 16'h0F0F}, 25, 1'b0, 16'h0, r, d);
      chk("R7 25-bit frame dropped", ctl_regs, model);
   endtask

   task automatic t_bad_opcode;
      logic [23:0] r; logic d;
      spi_frame({3'd7, 5'h0, 16'hDEAD}, 24, 1'b0, 16'h0, r, d);
      chk("R8 opcode 7 dropped", ctl_regs, model);
   endtask

   task automatic t_idle_clocking;
      bit seen = 1'b0;
      for (int i = 0; i < 30; i++) begin
         si = i[0]; sclk = 1'b1; wait_clk(3);
         if (so_en) seen = 1'b1;
         sclk = 1'b0; wait_clk(3);
      end
      wait_clk(6);
      chk("R2 idle clocking changes nothing", ctl_regs, model);
      chk("R2 so_en stays low", 112'(seen), 112'h0);
   endtask

   task automatic t_reply;
      logic [23:0] r; logic d;
      fault_in = 16'h8001; ovp_in = 1'b0;
      spi_frame(24'h0, 24, 1'b0, 16'h0, r, d);
      chk("R4 R5 reply outer faults", 112'(r), 112'h808001);
      chk("R9 so_en while selected", 112'(d), 112'h1);
      fault_in = 16'h0; ovp_in = 1'b1;
      spi_frame(24'h0, 24, 1'b0, 16'h0, r, d);
      chk("R4 reply overvoltage only", 112'(r), 112'hC00000);
      ovp_in = 1'b0;
      spi_frame(24'h0, 24, 1'b0, 16'h0, r, d);
      chk("R4 reply all clear", 112'(r), 112'h0);
      fault_in = 16'h00F0;
      spi_frame(24'h0, 24, 1'b1, 16'hFFFF, r, d);
      chk("R4 snapshot frozen at select", 112'(r), 112'h8000F0);
      fault_in = 16'h0;
      chk("R7 all-zero read frame wrote register 0", ctl_regs, set_reg(model, 0, 16'h0));
      model = set_reg(model, 0, 16'h0);
   endtask

   task automatic t_reset_again;
      logic [23:0] r; logic d;
      spi_frame({3'd0, 5'h0, 16'h5AA5}, 24, 1'b0, 16'h0, r, d);
      chk("R6 rewrite before reset", 112'(chan_on), 112'h5AA5);
      @(negedge clk); rst_n = 1'b0;
      wait_clk(2);
      chk("R1 reset clears bank", ctl_regs, 112'h0);
      rst_n = 1'b1;
      wait_clk(4);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
            finish_run();
         end
      end
   end

   initial begin
      wait_clk(5);
      t_reset();
      rst_n = 1'b1;
      wait_clk(5);
      t_write_enables();
      t_write_other();
      t_bad_length();
      t_bad_opcode();
      t_idle_clocking();
      t_reply();
      t_reset_again();
      finish_run();
   end
endmodule